// File: doc/BRIEF.md
# Event Translation Command Engine

This engine resolves a (device, event) pair into a physical interrupt number and a collection number. It does so by walking three in-memory tables in sequence: the device table, the per-device translation table, and the collection table. Requests arrive one at a time from a command front end. There are four request kinds. A translation-register write carries the event number in its data, and the bus requester ID names the device. The three queue commands are interrupt, clear and discard.

For a queue command, the engine first reads the command's second doubleword from the command queue, which is where the event number lives. It then checks each entry it fetches and gives up quietly when a device number, event number or entry is unusable. A discard that resolves successfully also erases the translation entry by writing zeros over it.

Every request ends with a one-cycle completion pulse and a status. The status is success, ignored or memory error. On success the engine also gives the translated interrupt and collection numbers. Delivering the interrupt onwards is left to other logic. All tables are flat. Memory is reached through one request/acknowledge port with at most one access outstanding.

Top module: `evt_xlate_engine`

## Requirements
- R1: After reset `req_ready_o` is 1, and `done_o` and `mem_req_o` are 0.
- R2: For a translation-register write (kind 0), the device number is `req_source_i` and the event number is `req_dw0_i[31:0]`. No command-queue read takes place. While `cfg_enable_i` is 0, such a write completes as ignored with no memory access.
- R3: For a queue command (kind 1 interrupt, 2 clear, 3 discard), the device number is `req_dw0_i[63:32]`. The event number is bits [31:0] of an 8-byte read at `cfg_cq_base_i + req_offset_i + 8`.
- R4: A device number above `cfg_max_dev_i` completes as ignored without any table read. Otherwise the device entry is read as 8 bytes at `cfg_dt_base_i + device*8`. Its bit 0 is the valid flag, and an invalid entry completes as ignored.
- R5: The device entry bits [5:1] hold a size s. An event number of 2^(s+1) or more completes as ignored without a translation-entry read. This holds for s = 31, where the limit is 2^32.
- R6: The translation table base is device-entry bits [47:8] with the low 8 address bits zero. The entry's low word is 8 bytes at base + event*12, and its high word is 4 bytes at base + event*12 + 8. The entry is usable only if low-word bits 0 and 1 are both 1. The interrupt number is low-word bits [25:2] and the collection number is high-word bits [15:0]. An unusable entry completes as ignored with no collection read.
- R7: The collection entry is read as 8 bytes at `cfg_ct_base_i + collection*8` only for a usable translation entry. Its bit 0 clear completes the request as ignored.
- R8: When every lookup is valid, kinds 0, 1 and 2 complete with status 0 (success) and the translated `intid_o` and `icid_o`, and they write nothing to memory.
- R9: A discard that passes every check writes 8 zero bytes at the low-word address and then 4 zero bytes at the high-word address before it completes as success. No other request kind and no failed discard writes memory.
- R10: An error response on any memory access ends the request at once with status 2 (memory error), and no further access is made.
- R11: Exactly one request is in flight at a time. `req_ready_o` is 0 from acceptance until completion. Completion is a single-cycle `done_o` with `status_o` 0 = success, 1 = ignored, 2 = memory error.
- R12: A memory access keeps `mem_req_o` high and the address, size and write data unchanged until `mem_ack_i`. For `mem_size_o`, 1 means 8 bytes and 0 means 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable_i | input | 1 | Allows translation-register writes |
| cfg_cq_base_i | input | 48 | Command queue base address |
| cfg_dt_base_i | input | 48 | Device table base address |
| cfg_ct_base_i | input | 48 | Collection table base address |
| cfg_max_dev_i | input | 32 | Highest legal device number |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request accepted this cycle if valid |
| req_kind_i | input | 2 | 0 register write, 1 interrupt, 2 clear, 3 discard |
| req_dw0_i | input | 64 | First command doubleword, or written data |
| req_source_i | input | 32 | Bus requester ID |
| req_offset_i | input | 20 | Command offset in the queue |
| done_o | output | 1 | Completion pulse |
| status_o | output | 2 | Completion status |
| intid_o | output | 24 | Translated interrupt number |
| icid_o | output | 16 | Translated collection number |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_size_o | output | 1 | 1 = 8 bytes, 0 = 4 bytes |
| mem_addr_o | output | 48 | Byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_ack_i | input | 1 | Access finished |
| mem_err_i | input | 1 | Access failed, valid with ack |
| mem_rdata_i | input | 64 | Read data, valid with ack |

## Verification
The bench drives the event-limit edges. It sends the last legal event and the first illegal one at a small size. It also sends event 0xFFFFFFFF at size 31, where a limit computed in 32 bits would wrap and wrongly reject the event. It sends a device one above the maximum, a translation entry that is valid but not physical, a collection entry that is invalid, and memory errors at the device-table and translation-table steps. For each case the number of memory accesses and writes is compared, so a design that walks past a failed check or keeps going after an error shows up. A discard is followed by a re-translation of the same event, which must now be ignored; a design that skipped or misplaced the zero write would still translate it.

// File: rtl/evt_xlate_pkg.sv
// Shared types and fixed entry layouts for the event translation engine.
// Assumes little-endian memory and flat (single-level) tables.
package evt_xlate_pkg;

    typedef enum logic [1:0] {
        KIND_XLATE   = 2'd0,
        KIND_INT     = 2'd1,
        KIND_CLEAR   = 2'd2,
        KIND_DISCARD = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_IGNORED = 2'd1,
        ST_MEMERR  = 2'd2
    } status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_EVT,
        S_RD_DTE,
        S_RD_ITEL,
        S_RD_ITEH,
        S_RD_CTE,
        S_WR_ITEL,
        S_WR_ITEH
    } state_e;

    localparam int EVT_W       = 32;   // event number width
    localparam int DEV_W       = 32;   // device number width
    localparam int SIZE_LSB    = 1;    // device entry size field
    localparam int SIZE_W      = 5;
    localparam int ITT_LSB     = 8;    // translation table base alignment
    localparam int INTID_LSB   = 2;    // interrupt number in low word
    localparam int ENTRY_BYTES = 8;    // device and collection entry size
    localparam int ITE_BYTES   = 12;   // translation entry size
    localparam int ITEH_OFFS   = 8;    // high word offset inside an entry

endpackage

// File: rtl/evt_addr_gen.sv
// Table walker address generator. Computes every address the engine can
// touch from the bases and the identifiers held so far. Purely combinational.
// Assumes flat tables and ADDR_W wide enough for base + index * entry size.
module evt_addr_gen
    import evt_xlate_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int OFFS_W = 20,
    parameter int COLL_W = 16
) (
    input  logic [ADDR_W-1:0] cq_base_i,
    input  logic [ADDR_W-1:0] dt_base_i,
    input  logic [ADDR_W-1:0] ct_base_i,
    input  logic [ADDR_W-1:0] itt_base_i,
    input  logic [OFFS_W-1:0] offset_i,
    input  logic [DEV_W-1:0]  devid_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [COLL_W-1:0] icid_i,
    output logic [ADDR_W-1:0] cq_addr_o,
    output logic [ADDR_W-1:0] dte_addr_o,
    output logic [ADDR_W-1:0] itel_addr_o,
    output logic [ADDR_W-1:0] iteh_addr_o,
    output logic [ADDR_W-1:0] cte_addr_o
);
    localparam logic [ADDR_W-1:0] DW_STEP = ADDR_W'(ENTRY_BYTES);
    localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(ITEH_OFFS);

    logic [ADDR_W-1:0] evt_ext;
    logic [ADDR_W-1:0] ite_offs;

    // Scale indices by entry sizes; event * 12 as (e*8) + (e*4).
    always_comb begin
        evt_ext     = ADDR_W'(evt_i);
        ite_offs    = (evt_ext << 3) + (evt_ext << 2);
        cq_addr_o   = cq_base_i + ADDR_W'(offset_i) + DW_STEP;
        dte_addr_o  = dt_base_i + (ADDR_W'(devid_i) << 3);
        itel_addr_o = itt_base_i + ite_offs;
        iteh_addr_o = itt_base_i + ite_offs + HI_STEP;
        cte_addr_o  = ct_base_i + (ADDR_W'(icid_i) << 3);
    end

endmodule

// File: rtl/evt_entry_decode.sv
// Entry decoder. Interprets one fetched doubleword as a device entry,
// translation low/high word or collection entry; the engine picks the view
// that matches its current step. Purely combinational.
module evt_entry_decode
    import evt_xlate_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int INTID_W = 24,
    parameter int COLL_W  = 16
) (
    input  logic [63:0]        data_i,
    input  logic [EVT_W-1:0]   evt_i,
    output logic               valid_o,
    output logic               evt_in_range_o,
    output logic [ADDR_W-1:0]  itt_base_o,
    output logic               ite_usable_o,
    output logic [INTID_W-1:0] intid_o,
    output logic [COLL_W-1:0]  icid_o
);
    logic [SIZE_W-1:0] size_f;
    logic [SIZE_W:0]   shift_amt;
    logic [EVT_W:0]    evt_limit;

    // Decode fields; limit kept one bit wider so 2^32 does not wrap.
    always_comb begin
        valid_o        = data_i[0];
        size_f         = data_i[SIZE_LSB +: SIZE_W];
        shift_amt      = {1'b0, size_f} + {{SIZE_W{1'b0}}, 1'b1};
        evt_limit      = (EVT_W+1)'(1) << shift_amt;
        evt_in_range_o = {1'b0, evt_i} < evt_limit;
        itt_base_o     = {data_i[ADDR_W-1:ITT_LSB], {ITT_LSB{1'b0}}};
        ite_usable_o   = data_i[0] & data_i[1];
        intid_o        = data_i[INTID_LSB +: INTID_W];
        icid_o         = data_i[COLL_W-1:0];
    end

endmodule

// File: rtl/evt_mem_port.sv
// Single-outstanding memory port. A launch pulse captures one access and
// holds it on the bus until acknowledged; the response is registered and
// reported with a one-cycle done pulse. Assumes launch only when idle.
module evt_mem_port #(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              we_i,
    input  logic              size8_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [63:0]       wdata_i,
    output logic              done_o,
    output logic              err_o,
    output logic [63:0]       rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_size_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [63:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    input  logic [63:0]       mem_rdata_i
);
    logic              req_q;
    logic              we_q;
    logic              size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [63:0]       wdata_q;
    logic              done_q;
    logic              err_q;
    logic [63:0]       rdata_q;

    // Hold the request until ack, then capture the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            size_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (launch_i && !req_q) begin
                req_q   <= 1'b1;
                we_q    <= we_i;
                size_q  <= size8_i;
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
            end else if (req_q && mem_ack_i) begin
                req_q   <= 1'b0;
                done_q  <= 1'b1;
                err_q   <= mem_err_i;
                rdata_q <= mem_rdata_i;
            end
        end
    end

    assign mem_req_o   = req_q;
    assign mem_we_o    = we_q;
    assign mem_size_o  = size_q;
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = wdata_q;
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign rdata_o     = rdata_q;

endmodule

// File: rtl/evt_xlate_engine.sv
// Event translation command engine. Accepts one request at a time, walks
// command queue, device, translation and collection entries through the
// memory port, validates each, erases the translation entry on a good
// discard and reports a status. Assumes flat tables and a memory that
// acknowledges every access.
module evt_xlate_engine
    import evt_xlate_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int OFFS_W  = 20,
    parameter int INTID_W = 24,
    parameter int COLL_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable_i,
    input  logic [ADDR_W-1:0]  cfg_cq_base_i,
    input  logic [ADDR_W-1:0]  cfg_dt_base_i,
    input  logic [ADDR_W-1:0]  cfg_ct_base_i,
    input  logic [DEV_W-1:0]   cfg_max_dev_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [1:0]         req_kind_i,
    input  logic [63:0]        req_dw0_i,
    input  logic [DEV_W-1:0]   req_source_i,
    input  logic [OFFS_W-1:0]  req_offset_i,
    output logic               done_o,
    output logic [1:0]         status_o,
    output logic [INTID_W-1:0] intid_o,
    output logic [COLL_W-1:0]  icid_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic               mem_size_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [63:0]        mem_wdata_o,
    input  logic               mem_ack_i,
    input  logic               mem_err_i,
    input  logic [63:0]        mem_rdata_i
);
    state_e             state_q;
    req_kind_e          kind_q;
    logic [DEV_W-1:0]   devid_q;
    logic [EVT_W-1:0]   evt_q;
    logic [OFFS_W-1:0]  offset_q;
    logic [ADDR_W-1:0]  itt_q;
    logic               usable_q;
    logic [INTID_W-1:0] intid_q;
    logic [COLL_W-1:0]  icid_q;
    logic               pend_q;
    logic               done_q;
    status_e            status_q;

    logic               launch;
    logic               acc_we;
    logic               acc_size8;
    logic [ADDR_W-1:0]  acc_addr;
    logic               port_done;
    logic               port_err;
    logic [63:0]        port_rdata;

    logic [ADDR_W-1:0]  cq_addr, dte_addr, itel_addr, iteh_addr, cte_addr;
    logic               ent_valid, ent_in_range, ent_usable;
    logic [ADDR_W-1:0]  ent_itt;
    logic [INTID_W-1:0] ent_intid;
    logic [COLL_W-1:0]  ent_icid;

    evt_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W),
        .COLL_W (COLL_W)
    ) u_addr (
        .cq_base_i   (cfg_cq_base_i),
        .dt_base_i   (cfg_dt_base_i),
        .ct_base_i   (cfg_ct_base_i),
        .itt_base_i  (itt_q),
        .offset_i    (offset_q),
        .devid_i     (devid_q),
        .evt_i       (evt_q),
        .icid_i      (icid_q),
        .cq_addr_o   (cq_addr),
        .dte_addr_o  (dte_addr),
        .itel_addr_o (itel_addr),
        .iteh_addr_o (iteh_addr),
        .cte_addr_o  (cte_addr)
    );

    evt_entry_decode #(
        .ADDR_W  (ADDR_W),
        .INTID_W (INTID_W),
        .COLL_W  (COLL_W)
    ) u_dec (
        .data_i         (port_rdata),
        .evt_i          (evt_q),
        .valid_o        (ent_valid),
        .evt_in_range_o (ent_in_range),
        .itt_base_o     (ent_itt),
        .ite_usable_o   (ent_usable),
        .intid_o        (ent_intid),
        .icid_o         (ent_icid)
    );

    evt_mem_port #(
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .we_i        (acc_we),
        .size8_i     (acc_size8),
        .addr_i      (acc_addr),
        .wdata_i     (64'd0),
        .done_o      (port_done),
        .err_o       (port_err),
        .rdata_o     (port_rdata),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_size_o  (mem_size_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ack_i   (mem_ack_i),
        .mem_err_i   (mem_err_i),
        .mem_rdata_i (mem_rdata_i)
    );

    // Select the access that belongs to the current step.
    always_comb begin
        acc_we    = 1'b0;
        acc_size8 = 1'b1;
        acc_addr  = '0;
        launch    = 1'b0;
        unique case (state_q)
            S_RD_EVT:  acc_addr = cq_addr;
            S_RD_DTE:  acc_addr = dte_addr;
            S_RD_ITEL: acc_addr = itel_addr;
            S_RD_ITEH: begin acc_addr = iteh_addr; acc_size8 = 1'b0; end
            S_RD_CTE:  acc_addr = cte_addr;
            S_WR_ITEL: begin acc_addr = itel_addr; acc_we = 1'b1; end
            S_WR_ITEH: begin acc_addr = iteh_addr; acc_we = 1'b1; acc_size8 = 1'b0; end
            default:   acc_addr = '0;
        endcase
        launch = (state_q != S_IDLE) && !pend_q;
    end

    // Track whether the current step's access is already on its way.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (launch)    pend_q <= 1'b1;
        else if (port_done) pend_q <= 1'b0;
    end

    // Request sequencer: accept, walk tables, validate, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            kind_q   <= KIND_XLATE;
            devid_q  <= '0;
            evt_q    <= '0;
            offset_q <= '0;
            itt_q    <= '0;
            usable_q <= 1'b0;
            intid_q  <= '0;
            icid_q   <= '0;
            done_q   <= 1'b0;
            status_q <= ST_OK;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid_i) begin
                        kind_q   <= req_kind_e'(req_kind_i);
                        offset_q <= req_offset_i;
                        if (req_kind_e'(req_kind_i) == KIND_XLATE) begin
                            devid_q <= req_source_i;
                            evt_q   <= req_dw0_i[EVT_W-1:0];
                            if (!cfg_enable_i || req_source_i > cfg_max_dev_i) begin
                                done_q   <= 1'b1;
                                status_q <= ST_IGNORED;
                            end else begin
                                state_q <= S_RD_DTE;
                            end
                        end else begin
                            devid_q <= req_dw0_i[63:32];
                            state_q <= S_RD_EVT;
                        end
                    end
                end
                S_RD_EVT: if (port_done) begin
                    if (port_err) begin
                        done_q <= 1'b1; status_q <= ST_MEMERR; state_q <= S_IDLE;
                    end else if (devid_q > cfg_max_dev_i) begin
                        done_q <= 1'b1; status_q <= ST_IGNORED; state_q <= S_IDLE;
                    end else begin
                        evt_q   <= port_rdata[EVT_W-1:0];
                        state_q <= S_RD_DTE;
                    end
                end
                S_RD_DTE: if (port_done) begin
                    if (port_err) begin
                        done_q <= 1'b1; status_q <= ST_MEMERR; state_q <= S_IDLE;
                    end else if (!ent_valid || !ent_in_range) begin
                        done_q <= 1'b1; status_q <= ST_IGNORED; state_q <= S_IDLE;
                    end else begin
                        itt_q   <= ent_itt;
                        state_q <= S_RD_ITEL;
                    end
                end
                S_RD_ITEL: if (port_done) begin
                    if (port_err) begin
                        done_q <= 1'b1; status_q <= ST_MEMERR; state_q <= S_IDLE;
                    end else begin
                        usable_q <= ent_usable;
                        intid_q  <= ent_intid;
                        state_q  <= S_RD_ITEH;
                    end
                end
                S_RD_ITEH: if (port_done) begin
                    if (port_err) begin
                        done_q <= 1'b1; status_q <= ST_MEMERR; state_q <= S_IDLE;
                    end else if (!usable_q) begin
                        done_q <= 1'b1; status_q <= ST_IGNORED; state_q <= S_IDLE;
                    end else begin
                        icid_q  <= ent_icid;
                        state_q <= S_RD_CTE;
                    end
                end
                S_RD_CTE: if (port_done) begin
                    if (port_err) begin
                        done_q <= 1'b1; status_q <= ST_MEMERR; state_q <= S_IDLE;
                    end else if (!ent_valid) begin
                        done_q <= 1'b1; status_q <= ST_IGNORED; state_q <= S_IDLE;
                    end else if (kind_q == KIND_DISCARD) begin
                        state_q <= S_WR_ITEL;
                    end else begin
                        done_q <= 1'b1; status_q <= ST_OK; state_q <= S_IDLE;
                    end
                end
                S_WR_ITEL: if (port_done) begin
                    if (port_err) begin
                        done_q <= 1'b1; status_q <= ST_MEMERR; state_q <= S_IDLE;
                    end else begin
                        state_q <= S_WR_ITEH;
                    end
                end
                S_WR_ITEH: if (port_done) begin
                    done_q   <= 1'b1;
                    status_q <= port_err ? ST_MEMERR : ST_OK;
                    state_q  <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready_o = (state_q == S_IDLE);
    assign done_o      = done_q;
    assign status_o    = status_q;
    assign intid_o     = intid_q;
    assign icid_o      = icid_q;

    // Bus access must stay put while waiting for the acknowledge.
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R12

    // Memory writes belong to discards only.
    AST_WRITE_ONLY_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> kind_q == KIND_DISCARD); // R9

    // Erasing writes carry zeros.
    AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> mem_wdata_o == 64'd0); // R9

    // No new request may be taken while memory traffic is in flight.
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o); // R11

    // An error response ends the request: the next cycle starts no access.
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i && mem_err_i |=> !mem_req_o); // R10

endmodule

// File: tb/test_evt_xlate_engine.sv
module test_evt_xlate_engine;
    localparam int AW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable;
    logic [AW-1:0] cq_base, dt_base, ct_base;
    logic [31:0]   max_dev;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_kind;
    logic [63:0]   req_dw0;
    logic [31:0]   req_source;
    logic [19:0]   req_offset;
    logic          done;
    logic [1:0]    status;
    logic [23:0]   intid;
    logic [15:0]   icid;
    logic          mem_req, mem_we, mem_size;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic          mem_ack;
    logic          mem_err;
    logic [63:0]   mem_rdata;

    always #2 clk = ~clk;   // 250 MHz

    evt_xlate_engine i_evt_xlate_engine (
        .clk(clk), .rst_n(rst_n), .cfg_enable_i(cfg_enable),
        .cfg_cq_base_i(cq_base), .cfg_dt_base_i(dt_base), .cfg_ct_base_i(ct_base),
        .cfg_max_dev_i(max_dev), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_kind_i(req_kind), .req_dw0_i(req_dw0), .req_source_i(req_source),
        .req_offset_i(req_offset), .done_o(done), .status_o(status),
        .intid_o(intid), .icid_o(icid), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_size_o(mem_size), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [logic [AW-1:0]];
    int acc_cnt = 0;
    int wr_cnt = 0;
    int wait_cnt = 0;

    function automatic logic [7:0] rd_byte(input logic [AW-1:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic put64(input logic [AW-1:0] a, input logic [63:0] d);
        for (int i = 0; i < 8; i++) mem[a + AW'(i)] = d[8*i +: 8];
    endtask

    task automatic put32(input logic [AW-1:0] a, input logic [31:0] d);
        for (int i = 0; i < 4; i++) mem[a + AW'(i)] = d[8*i +: 8];
    endtask

    function automatic logic [63:0] get64(input logic [AW-1:0] a);
        logic [63:0] d;
        for (int i = 0; i < 8; i++) d[8*i +: 8] = rd_byte(a + AW'(i));
        return d;
    endfunction

    // Acknowledge each access after two waiting cycles; bit 47 set is an error.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (wait_cnt == 1) begin
                wait_cnt = 0;
                acc_cnt++;
                mem_ack <= 1'b1;
                mem_err <= mem_addr[AW-1];
                mem_rdata <= 64'hDEAD_BEEF_DEAD_BEEF;
                if (!mem_addr[AW-1]) begin
                    if (mem_we) begin
                        wr_cnt++;
                        for (int i = 0; i < (mem_size ? 8 : 4); i++)
                            mem[mem_addr + AW'(i)] = mem_wdata[8*i +: 8];
                    end else begin
                        logic [63:0] d;
                        d = get64(mem_addr);
                        if (!mem_size) d[63:32] = 32'd0;
                        mem_rdata <= d;
                    end
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [1:0]  st;
        logic [23:0] iid;
        logic [15:0] cid;
        int          acc;
        int          wr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int acc_mark = 0;
    int wr_mark = 0;

    // Monitor: pop the expected item on each completion and compare.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(status == e.st, {e.tag, " status"}, status, e.st);
                if (e.st == 2'd0) begin
                    chk(intid == e.iid, {e.tag, " intid"}, intid, e.iid);
                    chk(icid == e.cid, {e.tag, " icid"}, icid, e.cid);
                end
                chk(acc_cnt - acc_mark == e.acc, {e.tag, " accesses"}, acc_cnt - acc_mark, e.acc);
                chk(wr_cnt - wr_mark == e.wr, {e.tag, " writes"}, wr_cnt - wr_mark, e.wr);
            end
            acc_mark = acc_cnt;
            wr_mark  = wr_cnt;
        end
    end

    // Driver: present one request, push its expectation, wait for completion.
    task automatic send(input logic [1:0] kind, input logic [31:0] dev, input logic [31:0] evt,
                        input logic [19:0] off, input logic [1:0] st, input logic [23:0] iid,
                        input logic [15:0] cid, input int acc, input int wr, input string tag);
        exp_t e;
        e.st = st; e.iid = iid; e.cid = cid; e.acc = acc; e.wr = wr; e.tag = tag;
        if (kind != 2'd0) put64(cq_base + AW'(off) + AW'(8), {32'd0, evt});
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        req_valid  = 1'b1;
        req_kind   = kind;
        req_offset = off;
        if (kind == 2'd0) begin
            req_source = dev;
            req_dw0    = {32'hFFFF_FFFF, evt};
        end else begin
            req_source = 32'h7777;
            req_dw0    = {dev, 32'h5555_5555};
        end
        @(negedge clk);
        req_valid = 1'b0;
        wait (exp_q.size() == 0);
    endtask

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cfg_enable = 1'b1;
        cq_base = 48'h1000; dt_base = 48'h2000; ct_base = 48'h3000;
        max_dev = 32'd15;
        req_valid = 1'b0; req_kind = 2'd0; req_dw0 = '0; req_source = '0; req_offset = '0;
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;

        // Device 2: valid, size 3 (16 events), table at 0x10000.
        put64(48'h2000 + 48'd16, 64'h10000 | (64'd3 << 1) | 64'd1);
        // Device 3: invalid. Device 4: size 0, table in error region.
        put64(48'h2000 + 48'd24, 64'h0);
        put64(48'h2000 + 48'd32, 64'h8000_0000_0000 | 64'd1);
        // Device 5: size 31, table at 0x20000.
        put64(48'h2000 + 48'd40, 64'h20000 | (64'd31 << 1) | 64'd1);
        // Translation entries of device 2.
        put64(48'h10000 + 48'd60,  (64'h2005 << 2) | 64'd3);  put32(48'h10000 + 48'd68, 32'd4);
        put64(48'h10000 + 48'd72,  64'd1);                    put32(48'h10000 + 48'd80, 32'd4);
        put64(48'h10000 + 48'd84,  (64'h2007 << 2) | 64'd3);  put32(48'h10000 + 48'd92, 32'd9);
        put64(48'h10000 + 48'd180, (64'h2100 << 2) | 64'd3);  put32(48'h10000 + 48'd188, 32'h0004);
        // Device 5, event 0xFFFFFFFF at 0x20000 + 0xBFFFFFFF4.
        put64(48'h20000 + 48'hB_FFFF_FFF4, (64'hABCDEF << 2) | 64'd3);
        put32(48'h20000 + 48'hB_FFFF_FFFC, 32'h0004);
        // Collections: 4 valid, 9 invalid.
        put64(48'h3000 + 48'd32, 64'd1);
        put64(48'h3000 + 48'd72, 64'd0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
        rst_n = 1'b1;

        send(2'd0, 2, 5, 0, 2'd0, 24'h2005, 16'd4, 4, 0, "R2 R8 register write translates");
        send(2'd1, 2, 5, 20'h20, 2'd0, 24'h2005, 16'd4, 5, 0, "R3 R8 interrupt command");
        send(2'd2, 2, 15, 20'h40, 2'd0, 24'h2100, 16'd4, 5, 0, "R5 R8 clear at last legal event");
        send(2'd0, 2, 16, 0, 2'd1, 0, 0, 1, 0, "R5 event at limit ignored");
        send(2'd1, 16, 5, 20'h60, 2'd1, 0, 0, 1, 0, "R4 device above max, queue");
        send(2'd0, 16, 5, 0, 2'd1, 0, 0, 0, 0, "R4 device above max, register write");
        send(2'd1, 3, 5, 20'h80, 2'd1, 0, 0, 2, 0, "R4 invalid device entry");
        send(2'd0, 2, 6, 0, 2'd1, 0, 0, 3, 0, "R6 non-physical entry ignored");
        send(2'd0, 2, 7, 0, 2'd1, 0, 0, 4, 0, "R7 invalid collection ignored");
        send(2'd3, 2, 6, 20'hA0, 2'd1, 0, 0, 4, 0, "R9 failed discard writes nothing");
        send(2'd0, 5, 32'hFFFF_FFFF, 0, 2'd0, 24'hABCDEF, 16'd4, 4, 0, "R5 R6 size 31 top event");
        send(2'd1, 4, 1, 20'hC0, 2'd2, 0, 0, 3, 0, "R10 error on translation read");

        cfg_enable = 1'b0;
        send(2'd0, 2, 5, 0, 2'd1, 0, 0, 0, 0, "R2 disabled register write");
        cfg_enable = 1'b1;

        dt_base = 48'h8000_0000_2000;
        send(2'd0, 2, 5, 0, 2'd2, 0, 0, 1, 0, "R10 error on device read");
        dt_base = 48'h2000;

        send(2'd3, 2, 15, 20'hE0, 2'd0, 24'h2100, 16'd4, 7, 2, "R9 discard erases entry");
        chk(get64(48'h10000 + 48'd180) == 64'd0, "R9 low word zeroed",
            get64(48'h10000 + 48'd180), 0);
        chk(get64(48'h10000 + 48'd188) == 64'd0, "R9 high word zeroed",
            get64(48'h10000 + 48'd188), 0);
        send(2'd0, 2, 15, 0, 2'd1, 0, 0, 3, 0, "R9 erased entry no longer translates");

        repeat (4) @(negedge clk);
        chk(mem_req == 1'b0 && req_ready == 1'b1, "R11 idle at end", {mem_req, req_ready}, 2'b01);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule